// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write a 32-entry, 8-bit register file over a four-wire synchronous serial link. The master opens a transfer by pulling the active-low select line down and closes it by releasing it. The first byte of a transfer is a command. It selects a register, chooses between reading and writing, and can raise a one-cycle acknowledge pulse that the surrounding logic uses to mark a control handshake as serviced. Each byte after the command is one data byte for the register file. After each data byte the internal address either holds or steps, depending on which region of the map it points at. Holding the address lets a FIFO port take any number of bytes inside one select window.

The serial pins are sampled by the block's own clock through synchronizer stages. Edges of the serial clock are detected inside the block, so the serial clock must be several times slower than the system clock. In full-duplex mode an 8-bit status word, taken from an input port, is shifted out on the data-out line while the command shifts in. In half-duplex mode the data-out line stays released, no status word is sent, and read data goes back to the master on the data-in line, which the block then drives.

Top module: `spi_rf_slave`

## Requirements
- R1: While select is high, both output enables are low, edges on the serial clock have no effect, and no register write occurs.
- R2: Incoming bits are captured on the rising serial-clock edge and outgoing bits change on the falling edge. Every byte travels most significant bit first.
- R3: The command byte carries the register number in bits 7:3 and the direction in bit 1 (1 = write, 0 = read). Bit 0 is the acknowledge flag. Bit 2 has no effect.
- R4: In full-duplex mode, the value on the status input at the falling edge of select is shifted out on the data-out line during the command byte.
- R5: After the eighth bit of each data byte in a write transfer, the write strobe is high for exactly one system-clock cycle, with the current address and the received byte.
- R6: In a read transfer, the register addressed for each data byte is latched before that byte's first bit is shifted out.
- R7: Addresses 0 to 4 do not change from one data byte to the next.
- R8: After each data byte, addresses 5 to 19 and 21 to 30 advance by one. Address 20 and address 31 stay where they are.
- R9: In half-duplex mode the data-out enable stays low. The data-in line is driven only in the data phase of a read transfer, and it then carries the read bytes. No status word is sent.
- R10: A write command with the acknowledge flag set gives exactly one acknowledge pulse. A read command gives no pulse, whatever the flag.
- R11: If select rises partway through a byte, the partial byte is discarded and causes no write.
- R12: After reset, both output enables, the write strobe and the acknowledge pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_duplex | input | 1 | 1 selects the shared single data line mode |
| sclk | input | 1 | Serial clock from the master, idle low |
| ss_n | input | 1 | Active-low select that frames each transfer |
| mosi_i | input | 1 | Serial data from the master |
| mosi_o | output | 1 | Read data driven back on the data-in line in half-duplex mode |
| mosi_oe | output | 1 | Drive enable for the data-in line |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for the data-out line |
| status_i | input | 8 | Status word sent during the command byte |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data for rf_raddr |
| rf_we | output | 1 | Register-file write strobe, one cycle per byte |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| ack_pulse | output | 1 | One-cycle acknowledge pulse from the command flag |

## Verification
The bench uses the default two synchronizer stages and a serial half period of six system clocks. With these settings the capture, reload and output-update latencies all fit inside one serial phase. Bursts are started just below each region boundary (4 to 5, 19 to 20, 30 to 31), so the hold and step rules meet within a few bytes. Both data-line modes are exercised against a register-file model in the bench, and a partial final byte is included.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int FIFO_TOP = 4;
  localparam int PIN_HOLD = 20;

  typedef struct packed {
    logic [ADDR_W-1:0] reg_num;
    logic              spare;
    logic              wr;
    logic              ack;
  } cmd_t;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    if (a <= ADDR_W'(FIFO_TOP) || a == ADDR_W'(PIN_HOLD) || a == {ADDR_W{1'b1}})
      return a;
    return a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rf_shift.sv
module spi_rf_shift #(
  parameter int DW  = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          ss_n_s,
  input  logic          sdi_s,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  output logic          active,
  output logic          sel_start,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          tx_bit
);
  localparam logic [CW-1:0] LAST = CW'(DW-1);

  logic          sclk_q, ss_q;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic          rise, fall;

  assign active    = ~ss_n_s;
  assign rise      = active & sclk_s & ~sclk_q;
  assign fall      = active & ~sclk_s & sclk_q;
  assign sel_start = ss_q & ~ss_n_s;
  assign byte_done = rise && (bit_cnt == LAST);
  assign rx_byte   = {rx_sh[DW-2:0], sdi_s};
  assign tx_bit    = tx_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_n_s;
    end
  end

  // bit counter and receive shifter; a partial byte is dropped when select rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (!active) begin
      bit_cnt <= '0;
    end else if (rise) begin
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CW'(1);
      rx_sh   <= rx_byte;
    end
  end

  // transmit shifter: no shift on the falling edge right after a byte boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tx_sh <= '0;
    else if (load_en)                 tx_sh <= load_val;
    else if (fall && bit_cnt != '0)   tx_sh <= {tx_sh[DW-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_rf_cmd.sv
module spi_rf_cmd
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [ADDR_W-1:0] addr,
  output logic              in_data,
  output logic              dir_wr,
  output logic              ack_pulse,
  output logic              reload,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  cmd_t cmd_w;
  assign cmd_w = cmd_t'(rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      in_data   <= 1'b0;
      dir_wr    <= 1'b0;
      ack_pulse <= 1'b0;
      reload    <= 1'b0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
    end else begin
      ack_pulse <= 1'b0;
      reload    <= 1'b0;
      rf_we     <= 1'b0;
      if (!active) begin
        in_data <= 1'b0;
        dir_wr  <= 1'b0;
      end else if (byte_done) begin
        reload <= 1'b1;
        if (!in_data) begin
          addr      <= cmd_w.reg_num;
          dir_wr    <= cmd_w.wr;
          in_data   <= 1'b1;
          ack_pulse <= cmd_w.wr & cmd_w.ack;
        end else begin
          if (dir_wr) begin
            rf_we    <= 1'b1;
            rf_waddr <= addr;
            rf_wdata <= rx_byte;
          end
          addr <= addr_step(addr);
        end
      end
    end
  end
endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_duplex,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic [DATA_W-1:0] status_i,
  output logic [ADDR_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              ack_pulse
);
  logic [2:0]        pins_s;
  logic              active, sel_start, byte_done, tx_bit;
  logic              in_data, dir_wr, reload, load_en;
  logic [DATA_W-1:0] rx_byte, load_val;
  logic [ADDR_W-1:0] addr;

  spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, ss_n, mosi_i}), .q(pins_s)
  );

  spi_rf_shift #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .ss_n_s(pins_s[1]), .sdi_s(pins_s[0]),
    .load_en(load_en), .load_val(load_val),
    .active(active), .sel_start(sel_start), .byte_done(byte_done),
    .rx_byte(rx_byte), .tx_bit(tx_bit)
  );

  spi_rf_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .active(active), .byte_done(byte_done),
    .rx_byte(rx_byte), .addr(addr), .in_data(in_data), .dir_wr(dir_wr),
    .ack_pulse(ack_pulse), .reload(reload), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  assign load_en  = sel_start | reload;
  always_comb begin
    if (sel_start)             load_val = half_duplex ? '0 : status_i;
    else if (in_data && !dir_wr) load_val = rf_rdata;
    else                       load_val = '0;
  end

  assign rf_raddr = addr;
  assign miso_o   = tx_bit;
  assign mosi_o   = tx_bit;
  assign miso_oe  = active & ~half_duplex;
  assign mosi_oe  = active & half_duplex & in_data & ~dir_wr;
endmodule

// File: rtl/spi_rf_checker.sv
module spi_rf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       half_duplex,
  input logic       active,
  input logic       byte_done,
  input logic       in_data,
  input logic       dir_wr,
  input logic [4:0] addr,
  input logic       rf_we,
  input logic       ack_pulse,
  input logic       miso_oe,
  input logic       mosi_oe
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!miso_oe && !mosi_oe));

  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_we_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(byte_done && in_data && dir_wr));

  assert_fifo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && addr <= 5'd4) |=> $stable(addr));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && addr > 5'd4 && addr != 5'd20 && addr != 5'd31)
      |=> (addr == $past(addr) + 5'd1));

  assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && (addr == 5'd20 || addr == 5'd31)) |=> $stable(addr));

  assert_ack_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> (in_data && dir_wr));

  assert_hd_quiet_miso_R9: assert property (@(posedge clk) disable iff (!rst_n)
    half_duplex |-> !miso_oe);
endmodule

bind spi_rf_slave spi_rf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .active(active),
  .byte_done(byte_done), .in_data(in_data), .dir_wr(dir_wr), .addr(addr),
  .rf_we(rf_we), .ack_pulse(ack_pulse), .miso_oe(miso_oe), .mosi_oe(mosi_oe)
);

// File: tb/tb_spi_rf_slave.sv
module tb_spi_rf_slave;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_duplex = 1'b0;
  logic       sclk = 1'b0;
  logic       ss_n = 1'b1;
  logic       mosi_i = 1'b0;
  logic       mosi_o, mosi_oe, miso_o, miso_oe;
  logic [7:0] status_i = 8'h5A;
  logic [4:0] rf_raddr, rf_waddr;
  logic [7:0] rf_rdata, rf_wdata;
  logic       rf_we, ack_pulse;

  int checks = 0;
  int fails  = 0;
  int acks   = 0;
  int idle_cnt = 0;
  int exp_a[$];
  int exp_d[$];
  logic [7:0] shadow [32];
  logic [7:0] regs [32];

  always #10 clk = ~clk;

  spi_rf_slave dut (
    .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .sclk(sclk),
    .ss_n(ss_n), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_o(miso_o), .miso_oe(miso_oe), .status_i(status_i),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .ack_pulse(ack_pulse)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // register file model seen by the design
  assign rf_rdata = regs[rf_raddr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= seed(i);
    end else if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
    end
  end

  function automatic int next_a(input int a);
    case (a)
      0, 1, 2, 3, 4, 20, 31: return a;
      default:               return a + 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we) begin
        if (exp_a.size() == 0) begin
          chk(0, "R5 R11 unexpected write", int'(rf_waddr), -1);
        end else begin
          int ea, ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(int'(rf_waddr) == ea && int'(rf_wdata) == ed, "R5 write",
              int'({rf_waddr, rf_wdata}), (ea << 8) | ed);
        end
      end
      if (ack_pulse) acks++;
      idle_cnt = ss_n ? idle_cnt + 1 : 0;
      if (idle_cnt > 4 && (miso_oe || mosi_oe))
        chk(0, "R1 idle enables", int'({miso_oe, mosi_oe}), 0);
    end
  end

  task automatic spi_bit(input logic b, output logic r);
    mosi_i = b;
    repeat (HALF) @(negedge clk);
    r = half_duplex ? mosi_o : miso_o;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic begin_x();
    @(negedge clk);
    ss_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_x();
    repeat (HALF) @(negedge clk);
    ss_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr_burst(input int a, input int n, input int base,
                          input logic ack, input logic spare, input string req);
    logic [7:0] st, junk;
    int cur, a0;
    a0 = acks;
    begin_x();
    spi_byte({5'(a), spare, 1'b1, ack}, st);
    if (!half_duplex) chk(st == status_i, "R4 status byte", int'(st), int'(status_i));
    cur = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(base + k);
      exp_a.push_back(cur);
      exp_d.push_back(int'(d));
      shadow[cur] = d;
      spi_byte(d, junk);
      cur = next_a(cur);
    end
    end_x();
    chk(exp_a.size() == 0, {req, " all writes seen"}, exp_a.size(), 0);
    chk(acks - a0 == int'(ack), "R10 ack count", acks - a0, int'(ack));
  endtask

  task automatic rd_burst(input int a, input int n, input logic ack, input string req);
    logic [7:0] st;
    int cur, a0;
    a0 = acks;
    begin_x();
    if (half_duplex)
      chk(!mosi_oe && !miso_oe, "R9 no drive in command", int'({miso_oe, mosi_oe}), 0);
    spi_byte({5'(a), 1'b0, 1'b0, ack}, st);
    if (half_duplex)
      chk(mosi_oe && !miso_oe, "R9 data-in driven", int'({miso_oe, mosi_oe}), 1);
    cur = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] r;
      spi_byte(8'h00, r);
      chk(r == shadow[cur], {req, " R2 R6 read"}, int'(r), int'(shadow[cur]));
      cur = next_a(cur);
    end
    end_x();
    chk(acks == a0, "R10 no ack on read", acks - a0, 0);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = seed(i);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!miso_oe && !mosi_oe && !rf_we && !ack_pulse, "R12 reset outputs",
        int'({miso_oe, mosi_oe, rf_we, ack_pulse}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: clock activity while deselected
    for (int i = 0; i < 10; i++) begin
      logic r;
      spi_bit(1'b1, r);
    end
    repeat (HALF) @(negedge clk);
    chk(!miso_oe && !mosi_oe, "R1 deselected", int'({miso_oe, mosi_oe}), 0);

    // R3 R8: incrementing region across 4/5 boundary start
    wr_burst(5, 4, 8'h10, 1'b0, 1'b0, "R3 R8");
    rd_burst(5, 4, 1'b0, "R8");
    // R7: FIFO region holds
    wr_burst(2, 3, 8'hC0, 1'b0, 1'b0, "R7");
    rd_burst(2, 2, 1'b0, "R7");
    wr_burst(4, 2, 8'hE0, 1'b0, 1'b0, "R7");
    // R8: hold at 20 and 31
    wr_burst(18, 4, 8'h30, 1'b0, 1'b0, "R8");
    rd_burst(18, 4, 1'b0, "R8");
    status_i = 8'hA3;
    wr_burst(29, 4, 8'h70, 1'b0, 1'b0, "R4 R8");
    rd_burst(29, 3, 1'b0, "R8");
    // R10: acknowledge flag
    wr_burst(9, 1, 8'h99, 1'b1, 1'b0, "R10");
    rd_burst(9, 1, 1'b1, "R10");
    // R3: spare bit ignored
    wr_burst(10, 2, 8'h44, 1'b0, 1'b1, "R3");
    rd_burst(10, 2, 1'b0, "R3");

    // R11: partial byte dropped
    begin
      logic [7:0] st, junk;
      begin_x();
      spi_byte({5'd12, 1'b0, 1'b1, 1'b0}, st);
      exp_a.push_back(12);
      exp_d.push_back(8'h6B);
      shadow[12] = 8'h6B;
      spi_byte(8'h6B, junk);
      for (int i = 0; i < 3; i++) begin
        logic r;
        spi_bit(1'b1, r);
      end
      end_x();
      chk(exp_a.size() == 0, "R11 only full byte written", exp_a.size(), 0);
      rd_burst(12, 2, 1'b0, "R11");
    end

    // R9: half-duplex
    half_duplex = 1'b1;
    repeat (4) @(negedge clk);
    wr_burst(22, 2, 8'hB4, 1'b0, 1'b0, "R9");
    rd_burst(22, 2, 1'b0, "R9");
    rd_burst(0, 1, 1'b0, "R9");

    report();
    $finish;
  end
endmodule